// File: doc/BRIEF.md
# Floating-Point Conditional Control Resolver

This block turns the already-evaluated outcome of a floating-point condition into the architectural effect of the instruction that tested it. Three instruction families are handled: a conditional branch with either a 16-bit or a 32-bit displacement, a decrement-and-branch loop whose counter lives in the low half of a data register, and a set-on-condition that writes an all-ones or all-zeros byte either into a data register or out to memory.

The caller presents the instruction kind, the condition flag, the PC of the first extension word, up to two displacement words and the current data register value, together with a one-cycle start strobe. One cycle later the block raises a done pulse together with the branch decision and next PC, the register write-back value and enable, and the store byte and strobe. Address generation, memory access and condition evaluation live elsewhere.

Top module: `fp_ctl_resolver`

## Requirements
- R1: `done_o` pulses high exactly in the cycle after `start_i` is high and is low otherwise; `taken_o`, `reg_we_o` and `store_o` are high only together with `done_o`. After reset every output is zero.
- R2: Kind 0 (short branch) with a nonzero 16-bit displacement and a true condition sets `taken_o` and drives `pc_o` = `pc_i` - 2 + sign-extended `disp_hi_i`.
- R3: Kind 0 with `disp_hi_i` equal to zero is a no-op for either condition value: `taken_o` low and `pc_o` equal to `pc_i`.
- R4: Kind 1 (long branch) forms its displacement as `{disp_hi_i, disp_lo_i}` (first word in the upper half) and, when the condition is true, drives `pc_o` = `pc_i` - 2 + that displacement with `taken_o` high.
- R5: Whenever `done_o` is high and `taken_o` is low, `pc_o` equals the `pc_i` given with the start strobe; a false condition on kinds 0 and 1 never branches.
- R6: Kind 2 (loop) with a true condition writes no register and does not branch.
- R7: Kind 2 with a false condition writes back the low 16 register bits decremented by one with the upper 16 bits unchanged; if the old low half was nonzero it branches to `pc_i` + sign-extended `disp_hi_i` (no minus 2).
- R8: Kind 2 with a false condition and an old low half of 0x0000 writes back 0xFFFF in the low half and falls through without branching.
- R9: Kind 3 (set register) writes back the register with its low byte replaced by 0xFF for a true condition or 0x00 for a false one, upper 24 bits kept, and no store strobe.
- R10: Kind 4 (set memory) raises `store_o` with `store_byte_o` 0xFF or 0x00 by condition and no register write or branch; kinds 5 to 7 produce only the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| kind_i | input | 3 | Instruction kind (0 short branch, 1 long branch, 2 loop, 3 set register, 4 set memory) |
| cond_i | input | 1 | Evaluated condition is true |
| pc_i | input | 32 | PC of the first extension word |
| disp_hi_i | input | 16 | First extension word (short/loop displacement, or long upper half) |
| disp_lo_i | input | 16 | Second extension word (long lower half) |
| reg_i | input | 32 | Current data register value |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Branch taken |
| pc_o | output | 32 | Next PC (target when taken, else `pc_i`) |
| reg_we_o | output | 1 | Data register write enable |
| reg_o | output | 32 | Data register write-back value |
| store_o | output | 1 | Memory byte store strobe |
| store_byte_o | output | 8 | Byte to store |

## Verification
The assertions watch on every cycle that the done pulse follows the start strobe by one cycle, that no strobe appears without it, that a non-taken result returns the incoming PC, that a true loop condition leaves register and PC alone, that the loop and register-set paths preserve the untouched upper register bits, and that a zero short displacement never branches. The exact branch arithmetic, the long displacement word order, the decremented counter value at the 0, 1 and 0xFFFF corners, and the 0xFF/0x00 byte values are shown only by the bench's scenarios, which compare every result against an independently computed expectation.

// File: rtl/fpcr_pkg.sv
package fpcr_pkg;
  typedef enum logic [2:0] {
    KIND_BRA_W   = 3'd0,
    KIND_BRA_L   = 3'd1,
    KIND_LOOP    = 3'd2,
    KIND_SET_REG = 3'd3,
    KIND_SET_MEM = 3'd4
  } fpcr_kind_e;
endpackage

// File: rtl/fpcr_branch_unit.sv
module fpcr_branch_unit #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              long_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_hi_i,
  input  logic [DISP_W-1:0] disp_lo_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int LONG_W = 2 * DISP_W;

  logic [LONG_W-1:0] disp_long;
  logic [ADDR_W-1:0] offset;
  logic              zero_short;

  assign disp_long  = {disp_hi_i, disp_lo_i};
  assign zero_short = !long_i && (disp_hi_i == '0);

  always_comb begin
    if (long_i) offset = ADDR_W'($signed(disp_long));
    else        offset = ADDR_W'($signed(disp_hi_i));
  end

  // target is relative to the opcode word, two bytes before the extension word
  assign target_o = pc_i - ADDR_W'(2) + offset;
  assign taken_o  = cond_i && !zero_short;
endmodule

// File: rtl/fpcr_loop_unit.sv
module fpcr_loop_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DISP_W = 16
) (
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic              we_o,
  output logic [DATA_W-1:0] reg_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);
  logic [CNT_W:0] dec;
  logic           borrow;

  assign dec      = {1'b0, reg_i[CNT_W-1:0]} - (CNT_W+1)'(1);
  assign borrow   = dec[CNT_W];
  assign we_o     = !cond_i;
  assign taken_o  = !cond_i && !borrow;
  assign target_o = pc_i + ADDR_W'($signed(disp_i));

  generate
    if (DATA_W > CNT_W) begin : g_keep_upper
      assign reg_o = {reg_i[DATA_W-1:CNT_W], dec[CNT_W-1:0]};
    end else begin : g_full
      assign reg_o = dec[DATA_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fpcr_set_unit.sv
module fpcr_set_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              cond_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic [DATA_W-1:0] reg_o
);
  assign byte_o = {BYTE_W{cond_i}};
  assign reg_o  = {reg_i[DATA_W-1:BYTE_W], byte_o};
endmodule

// File: rtl/fp_ctl_resolver.sv
module fp_ctl_resolver
  import fpcr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int DISP_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        kind_i,
  input  logic              cond_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_hi_i,
  input  logic [DISP_W-1:0] disp_lo_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_o,
  output logic              store_o,
  output logic [BYTE_W-1:0] store_byte_o
);
  fpcr_kind_e kind;
  assign kind = fpcr_kind_e'(kind_i);

  logic              br_taken;
  logic [ADDR_W-1:0] br_target;
  logic              lp_we, lp_taken;
  logic [DATA_W-1:0] lp_reg;
  logic [ADDR_W-1:0] lp_target;
  logic [BYTE_W-1:0] st_byte;
  logic [DATA_W-1:0] st_reg;

  fpcr_branch_unit #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_branch (
    .long_i    (kind == KIND_BRA_L),
    .cond_i    (cond_i),
    .pc_i      (pc_i),
    .disp_hi_i (disp_hi_i),
    .disp_lo_i (disp_lo_i),
    .taken_o   (br_taken),
    .target_o  (br_target)
  );

  fpcr_loop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DISP_W(DISP_W)) u_loop (
    .cond_i   (cond_i),
    .pc_i     (pc_i),
    .disp_i   (disp_hi_i),
    .reg_i    (reg_i),
    .we_o     (lp_we),
    .reg_o    (lp_reg),
    .taken_o  (lp_taken),
    .target_o (lp_target)
  );

  fpcr_set_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_set (
    .cond_i (cond_i),
    .reg_i  (reg_i),
    .byte_o (st_byte),
    .reg_o  (st_reg)
  );

  logic              nx_taken, nx_we, nx_store;
  logic [ADDR_W-1:0] nx_pc;
  logic [DATA_W-1:0] nx_reg;

  always_comb begin
    nx_taken = 1'b0;
    nx_pc    = pc_i;
    nx_we    = 1'b0;
    nx_reg   = reg_i;
    nx_store = 1'b0;
    unique case (kind)
      KIND_BRA_W, KIND_BRA_L: begin
        nx_taken = br_taken;
        if (br_taken) nx_pc = br_target;
      end
      KIND_LOOP: begin
        nx_we    = lp_we;
        nx_reg   = lp_reg;
        nx_taken = lp_taken;
        if (lp_taken) nx_pc = lp_target;
      end
      KIND_SET_REG: begin
        nx_we  = 1'b1;
        nx_reg = st_reg;
      end
      KIND_SET_MEM: nx_store = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      taken_o      <= 1'b0;
      pc_o         <= '0;
      reg_we_o     <= 1'b0;
      reg_o        <= '0;
      store_o      <= 1'b0;
      store_byte_o <= '0;
    end else begin
      done_o   <= start_i;
      taken_o  <= start_i && nx_taken;
      reg_we_o <= start_i && nx_we;
      store_o  <= start_i && nx_store;
      if (start_i) begin
        pc_o         <= nx_pc;
        reg_o        <= nx_reg;
        store_byte_o <= st_byte;
      end
    end
  end

  assert_done_follows_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  assert_done_only_after_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);
  assert_strobes_need_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taken_o || reg_we_o || store_o) |-> done_o);
  assert_zero_disp_nop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && kind_i == 3'd0 && disp_hi_i == '0) |=> (!taken_o && pc_o == $past(pc_i)));
  assert_fallthrough_pc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (taken_o || pc_o == $past(pc_i)));
  assert_loop_true_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && kind_i == 3'd2 && cond_i) |=> (!reg_we_o && !taken_o));
  assert_loop_upper_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && kind_i == 3'd2 && !cond_i) |=>
      (reg_we_o && reg_o[DATA_W-1:CNT_W] == $past(reg_i[DATA_W-1:CNT_W])));
  assert_set_upper_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && kind_i == 3'd3) |=>
      (reg_we_o && !store_o && reg_o[DATA_W-1:BYTE_W] == $past(reg_i[DATA_W-1:BYTE_W])));
  assert_store_alone_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> (!reg_we_o && !taken_o));
endmodule

// File: tb/fp_ctl_resolver_tb.sv
module fp_ctl_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  kind = '0;
  logic        cond = 1'b0;
  logic [31:0] pc = '0;
  logic [15:0] dh = '0, dl = '0;
  logic [31:0] rv = '0;
  logic        done, taken, we, st;
  logic [31:0] pc_out, reg_out;
  logic [7:0]  sbyte;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic        taken;
    logic [31:0] pc;
    logic        we;
    logic [31:0] rv;
    logic        st;
    logic [7:0]  sb;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_ctl_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .kind_i(kind), .cond_i(cond),
    .pc_i(pc), .disp_hi_i(dh), .disp_lo_i(dl), .reg_i(rv),
    .done_o(done), .taken_o(taken), .pc_o(pc_out), .reg_we_o(we), .reg_o(reg_out),
    .store_o(st), .store_byte_o(sbyte)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic c, input logic [31:0] p,
                       input logic [15:0] h, input logic [15:0] l,
                       input logic [31:0] r, input string req);
    exp_t e;
    e = '0;
    e.pc = p;
    case (k)
      3'd0: if (c && h != 16'h0) begin
              e.taken = 1'b1;
              e.pc = p - 32'd2 + {{16{h[15]}}, h};
            end
      3'd1: if (c) begin
              e.taken = 1'b1;
              e.pc = p - 32'd2 + {h, l};
            end
      3'd2: if (!c) begin
              e.we = 1'b1;
              e.rv = {r[31:16], r[15:0] - 16'd1};
              if (r[15:0] != 16'h0) begin
                e.taken = 1'b1;
                e.pc = p + {{16{h[15]}}, h};
              end
            end
      3'd3: begin
              e.we = 1'b1;
              e.rv = {r[31:8], c ? 8'hFF : 8'h00};
            end
      3'd4: begin
              e.st = 1'b1;
              e.sb = c ? 8'hFF : 8'h00;
            end
      default: ;
    endcase
    @(negedge clk);
    kind = k; cond = c; pc = p; dh = h; dl = l; rv = r;
    exp_q.push_back(e);
    req_q.push_back(req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t  e;
          string q;
          e = exp_q.pop_front();
          q = req_q.pop_front();
          chk(taken == e.taken, q, "taken", 32'(taken), 32'(e.taken));
          chk(pc_out == e.pc, q, "pc", pc_out, e.pc);
          chk(we == e.we, q, "reg_we", 32'(we), 32'(e.we));
          chk(st == e.st, q, "store", 32'(st), 32'(e.st));
          if (e.we) chk(reg_out == e.rv, q, "reg", reg_out, e.rv);
          if (e.st) chk(sbyte == e.sb, q, "byte", 32'(sbyte), 32'(e.sb));
        end
      end else if (taken || we || st) begin
        chk(1'b0, "R1", "strobe without done", {29'd0, taken, we, st}, 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !taken && !we && !st, "R1", "reset strobes", {28'd0, done, taken, we, st}, 32'd0);
    chk(pc_out == 32'd0 && reg_out == 32'd0, "R1", "reset data", pc_out | reg_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    drive(3'd0, 1'b1, 32'h0000_1000, 16'h0010, 16'h0, 32'h0, "R2");
    drive(3'd0, 1'b1, 32'h0000_1000, 16'hFFF0, 16'h0, 32'h0, "R2");
    drive(3'd0, 1'b1, 32'h0000_2000, 16'h0000, 16'h0, 32'h0, "R3");
    drive(3'd0, 1'b0, 32'h0000_2000, 16'h0000, 16'h0, 32'h0, "R3");
    drive(3'd0, 1'b0, 32'h0000_3000, 16'h0040, 16'h0, 32'h0, "R5");
    drive(3'd1, 1'b1, 32'h0000_4000, 16'h0001, 16'h0000, 32'h0, "R4");
    drive(3'd1, 1'b1, 32'h0010_0000, 16'hFFFF, 16'hFFFE, 32'h0, "R4");
    drive(3'd1, 1'b1, 32'h0000_4000, 16'h0000, 16'h0000, 32'h0, "R4");
    drive(3'd1, 1'b0, 32'h0000_5000, 16'h1234, 16'h5678, 32'h0, "R5");
    // loop counter sweep
    foreach (drive_cnt[i]) begin end
    drive(3'd2, 1'b1, 32'h0000_6000, 16'hFFF8, 16'h0, 32'hABCD_0000, "R6");
    drive(3'd2, 1'b1, 32'h0000_6000, 16'hFFF8, 16'h0, 32'hABCD_0001, "R6");
    drive(3'd2, 1'b1, 32'h0000_6000, 16'hFFF8, 16'h0, 32'hABCD_FFFF, "R6");
    drive(3'd2, 1'b0, 32'h0000_6000, 16'hFFF8, 16'h0, 32'hABCD_0001, "R7");
    drive(3'd2, 1'b0, 32'h0000_6000, 16'h0020, 16'h0, 32'hABCD_FFFF, "R7");
    drive(3'd2, 1'b0, 32'h0000_6000, 16'hFFF8, 16'h0, 32'hABCD_0000, "R8");
    drive(3'd3, 1'b1, 32'h0000_7000, 16'h0, 16'h0, 32'h1234_5678, "R9");
    drive(3'd3, 1'b0, 32'h0000_7000, 16'h0, 16'h0, 32'h1234_56FF, "R9");
    drive(3'd4, 1'b1, 32'h0000_8000, 16'h0, 16'h0, 32'h1111_2222, "R10");
    drive(3'd4, 1'b0, 32'h0000_8000, 16'h0, 16'h0, 32'h1111_2222, "R10");
    drive(3'd6, 1'b1, 32'h0000_9000, 16'h0010, 16'h0, 32'h3333_4444, "R10");
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "pending results", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int drive_cnt[1];
endmodule